// File: doc/BRIEF.md
# Deskew Reference Frame Generator and Checker

This block drives the transmit side of a deskew control lane that runs next to a group of parallel data lanes. Each data lane presents one 68-bit unit per strobe, made of 64 data bits and 4 control bits. Units are paired, counted from reset. On the first unit of every pair the block takes the top data byte of each lane and builds a 136-bit reference frame. The frame has a 32-bit sync pattern, one sample byte per lane in lane order, and a CRC-24 over everything before it. A serializer shifts the frame out MSB first, one bit per clock, with a bit-valid qualifier. The start of the sync pattern marks the first unit of the matching pair on every data lane, so a far end can measure the skew of each data lane against the control lane.

The same block contains a receive-side frame checker. It takes a serial bit stream with its own bit-valid, searches bit by bit for a frame whose sync pattern and CRC are both correct, then follows frame boundaries. It declares lock after a run of good frames and drops lock after a run of bad ones.

Top module: `deskew_ref_gen`

## Requirements
- R1: After reset `ser_valid_o`, `chk_lock_o`, `chk_good_o` and `chk_bad_o` are all low.
- R2: Each frame is 136 bits sent MSB first: bytes F6, F6, 28, 28, then ten sample bytes for lanes 0 to 9, then the 24-bit CRC.
- R3: Lane n occupies `lane_words_i[n*68 +: 68]` with data in the low 64 bits; its sample byte is data bits 63:56 of the first unit of a pair; the second unit's contents do not affect any frame.
- R4: The CRC is computed over the first 112 frame bits, MSB first, with generator 0x864CFB (x^24 implied), start value 0xB704CE and no final inversion.
- R5: Accepted units alternate first/second of a pair starting from reset; exactly one frame is produced per pair, on its first unit.
- R6: While a frame is shifting, `ser_valid_o` stays high for 136 consecutive clocks, and a waiting frame follows the previous one with no idle clock between them.
- R7: A frame built while the serializer is busy waits in a single slot; a newer frame replaces one that is still waiting, so the older one is never sent.
- R8: The checker pulses `chk_good_o` for one clock at the end of each frame that has the correct sync pattern and CRC, and raises `chk_lock_o` at the end of the second consecutive good frame.
- R9: While locked, each frame with a wrong sync pattern or CRC pulses `chk_bad_o`; lock drops at the end of the fourth consecutive bad frame, and a good frame before then clears the run.
- R10: While unlocked and searching, the checker finds a frame at any bit offset, gives no pulse for frames that fail, and ignores clocks with `chk_valid_i` low.
- R11: A bad frame after the first good one, before lock, pulses `chk_bad_o` and sends the checker back to searching, so two fresh good frames are needed for lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_words_i | input | 680 | Ten 68-bit lane units, lane n at bits n*68 +: 68 |
| unit_valid_i | input | 1 | One unit accepted on every lane this clock |
| ser_bit_o | output | 1 | Serial frame bit, MSB first |
| ser_valid_o | output | 1 | `ser_bit_o` carries a frame bit |
| chk_bit_i | input | 1 | Serial bit into the checker |
| chk_valid_i | input | 1 | `chk_bit_i` carries a bit |
| chk_lock_o | output | 1 | Checker is locked to frame boundaries |
| chk_good_o | output | 1 | One-clock pulse: a good frame just ended |
| chk_bad_o | output | 1 | One-clock pulse: a frame boundary failed |

## Verification
The bench sweeps lane patterns including all-ones and all-zeros words, where a CRC with a wrong start value or bit order, or a lane sample taken from the wrong byte or the second unit, would give a mismatching frame. Units are sent back to back so that a design that drops the waiting frame, sends the stale one, or leaves a gap between frames is caught through the frame order and the valid run length. The checker is given junk before its first frame, bit gaps, runs of exactly three and four bad frames, and a bad frame between the first and second good frame; a design with off-by-one lock or unlock counts, or one that locks straight after a break in the good run, would show the wrong lock level at the end of a frame.

// File: rtl/ref_frame_pkg.sv
package ref_frame_pkg;

    localparam int SYNC_W = 32;
    localparam int SAMP_W = 8;
    localparam int CRC_W  = 24;

    localparam logic [7:0]        SYNC_A    = 8'hF6;
    localparam logic [7:0]        SYNC_B    = 8'h28;
    localparam logic [SYNC_W-1:0] SYNC_WORD = {SYNC_A, SYNC_A, SYNC_B, SYNC_B};

    localparam logic [CRC_W-1:0] CRC_POLY = 24'h864CFB;
    localparam logic [CRC_W-1:0] CRC_INIT = 24'hB704CE;

    typedef enum logic [1:0] {
        CK_HUNT   = 2'd0,
        CK_VERIFY = 2'd1,
        CK_LOCKED = 2'd2
    } chk_state_e;

endpackage

// File: rtl/ref_crc24.sv
module ref_crc24
    import ref_frame_pkg::*;
#(
    parameter int W = 112
) (
    input  logic [W-1:0]     msg_i,
    output logic [CRC_W-1:0] crc_o
);

    logic [CRC_W-1:0] crc_v;
    logic             fb;

    // Bitwise serial CRC, MSB of the message first, unrolled over W bits
    always_comb begin
        crc_v = CRC_INIT;
        fb    = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            fb    = crc_v[CRC_W-1] ^ msg_i[i];
            crc_v = {crc_v[CRC_W-2:0], 1'b0};
            if (fb) begin
                crc_v = crc_v ^ CRC_POLY;
            end
        end
        crc_o = crc_v;
    end

endmodule

// File: rtl/ref_frame_build.sv
module ref_frame_build
    import ref_frame_pkg::*;
#(
    parameter int NLANE  = 10,
    parameter int DATA_W = 64,
    parameter int CTRL_W = 4,
    localparam int UNIT_W  = DATA_W + CTRL_W,
    localparam int BODY_W  = SYNC_W + SAMP_W * NLANE,
    localparam int FRAME_W = BODY_W + CRC_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NLANE*UNIT_W-1:0] lane_words_i,
    input  logic                    unit_valid_i,
    input  logic                    take_i,
    output logic                    hold_v_o,
    output logic [FRAME_W-1:0]      hold_frame_o
);

    typedef struct packed {
        logic               phase;
        logic               hold_v;
        logic [FRAME_W-1:0] frame;
    } bld_t;

    bld_t s_d, s_q;

    logic [BODY_W-1:0] body;
    logic [CRC_W-1:0]  body_crc;
    logic              ctl_unused;

    assign body[BODY_W-1 -: SYNC_W] = SYNC_WORD;

    // Sample bytes in lane order directly after the sync pattern
    for (genvar n = 0; n < NLANE; n++) begin : g_sample
        assign body[BODY_W-SYNC_W-1-SAMP_W*n -: SAMP_W] =
            lane_words_i[n*UNIT_W + DATA_W - 1 -: SAMP_W];
    end

    assign ctl_unused = ^lane_words_i;

    ref_crc24 #(.W(BODY_W)) u_crc (
        .msg_i (body),
        .crc_o (body_crc)
    );

    always_comb begin
        s_d = s_q;
        if (take_i) begin
            s_d.hold_v = 1'b0;
        end
        if (unit_valid_i) begin
            if (!s_q.phase) begin
                s_d.hold_v = 1'b1;
                s_d.frame  = {body, body_crc};
            end
            s_d.phase = ~s_q.phase;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign hold_v_o     = s_q.hold_v;
    assign hold_frame_o = s_q.frame;

    logic phase_q;
    assign phase_q = s_q.phase;

    // R5
    phase_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unit_valid_i |=> (phase_q != $past(phase_q)));

    // R5
    hold_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_valid_i && !phase_q) |=> hold_v_o);

endmodule

// File: rtl/ref_frame_shift.sv
module ref_frame_shift
    import ref_frame_pkg::*;
#(
    parameter int FRAME_W = 136,
    localparam int CNT_W = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold_v_i,
    input  logic [FRAME_W-1:0] hold_frame_i,
    output logic               take_o,
    output logic               ser_bit_o,
    output logic               ser_valid_o
);

    typedef struct packed {
        logic [FRAME_W-1:0] sh;
        logic [CNT_W-1:0]   cnt;
    } shf_t;

    shf_t s_d, s_q;

    // Reload on the clock that sends the last bit, so frames abut
    assign take_o = hold_v_i && (s_q.cnt <= CNT_W'(1));

    always_comb begin
        s_d = s_q;
        if (take_o) begin
            s_d.sh  = hold_frame_i;
            s_d.cnt = CNT_W'(FRAME_W);
        end else if (s_q.cnt != '0) begin
            s_d.sh  = {s_q.sh[FRAME_W-2:0], 1'b0};
            s_d.cnt = s_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ser_bit_o   = s_q.sh[FRAME_W-1];
    assign ser_valid_o = (s_q.cnt != '0);

    logic [CNT_W-1:0]  cnt_q;
    logic [SYNC_W-1:0] head_q;
    assign cnt_q  = s_q.cnt;
    assign head_q = s_q.sh[FRAME_W-1 -: SYNC_W];

    // R6
    busy_no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R2
    frame_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> (head_q == SYNC_WORD && ser_valid_o));

endmodule

// File: rtl/ref_frame_check.sv
module ref_frame_check
    import ref_frame_pkg::*;
#(
    parameter int FRAME_W    = 136,
    parameter int LOCK_GOOD  = 2,
    parameter int UNLOCK_BAD = 4,
    localparam int BODY_W = FRAME_W - CRC_W,
    localparam int PW     = $clog2(FRAME_W),
    localparam int GW     = $clog2(LOCK_GOOD + 1),
    localparam int BW     = $clog2(UNLOCK_BAD + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    input  logic valid_i,
    output logic lock_o,
    output logic good_o,
    output logic bad_o
);

    localparam logic [GW-1:0] GOOD_N = GW'(LOCK_GOOD);
    localparam logic [BW-1:0] BAD_N  = BW'(UNLOCK_BAD);
    localparam logic [PW-1:0] LAST_P = PW'(FRAME_W - 1);

    typedef struct packed {
        chk_state_e         st;
        logic [FRAME_W-1:0] win;
        logic [PW-1:0]      pos;
        logic [GW-1:0]      gcnt;
        logic [BW-1:0]      bcnt;
        logic               lock;
        logic               good;
        logic               bad;
    } chk_t;

    chk_t s_d, s_q;

    logic [FRAME_W-1:0] win_n;
    logic [CRC_W-1:0]   win_crc;
    logic               frame_ok;
    logic [GW-1:0]      gcnt_inc;
    logic [BW-1:0]      bcnt_inc;

    assign win_n    = {s_q.win[FRAME_W-2:0], bit_i};
    assign gcnt_inc = s_q.gcnt + GW'(1);
    assign bcnt_inc = s_q.bcnt + BW'(1);

    ref_crc24 #(.W(BODY_W)) u_crc (
        .msg_i (win_n[FRAME_W-1:CRC_W]),
        .crc_o (win_crc)
    );

    assign frame_ok = (win_n[FRAME_W-1 -: SYNC_W] == SYNC_WORD) &&
                      (win_crc == win_n[CRC_W-1:0]);

    always_comb begin
        s_d      = s_q;
        s_d.good = 1'b0;
        s_d.bad  = 1'b0;
        if (valid_i) begin
            s_d.win = win_n;
            unique case (s_q.st)
                CK_HUNT: begin
                    if (frame_ok) begin
                        s_d.good = 1'b1;
                        s_d.pos  = '0;
                        s_d.gcnt = GW'(1);
                        if (GW'(1) >= GOOD_N) begin
                            s_d.st   = CK_LOCKED;
                            s_d.lock = 1'b1;
                            s_d.bcnt = '0;
                        end else begin
                            s_d.st = CK_VERIFY;
                        end
                    end
                end
                CK_VERIFY, CK_LOCKED: begin
                    if (s_q.pos == LAST_P) begin
                        s_d.pos = '0;
                        if (frame_ok) begin
                            s_d.good = 1'b1;
                            s_d.bcnt = '0;
                            if (s_q.st == CK_VERIFY) begin
                                s_d.gcnt = gcnt_inc;
                                if (gcnt_inc >= GOOD_N) begin
                                    s_d.st   = CK_LOCKED;
                                    s_d.lock = 1'b1;
                                end
                            end
                        end else begin
                            s_d.bad = 1'b1;
                            if (s_q.st == CK_VERIFY) begin
                                s_d.st   = CK_HUNT;
                                s_d.gcnt = '0;
                            end else if (bcnt_inc >= BAD_N) begin
                                s_d.st   = CK_HUNT;
                                s_d.lock = 1'b0;
                                s_d.bcnt = '0;
                                s_d.gcnt = '0;
                            end else begin
                                s_d.bcnt = bcnt_inc;
                            end
                        end
                    end else begin
                        s_d.pos = s_q.pos + PW'(1);
                    end
                end
                default: begin
                    s_d.st = CK_HUNT;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign lock_o = s_q.lock;
    assign good_o = s_q.good;
    assign bad_o  = s_q.bad;

    // R8
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> good_o);

    // R9
    lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_o) |-> bad_o);

    // R8
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(good_o && bad_o));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!good_o && !bad_o && $stable(lock_o)));

endmodule

// File: rtl/deskew_ref_gen.sv
module deskew_ref_gen
    import ref_frame_pkg::*;
#(
    parameter int NLANE      = 10,
    parameter int DATA_W     = 64,
    parameter int CTRL_W     = 4,
    parameter int LOCK_GOOD  = 2,
    parameter int UNLOCK_BAD = 4,
    localparam int UNIT_W  = DATA_W + CTRL_W,
    localparam int FRAME_W = SYNC_W + SAMP_W * NLANE + CRC_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NLANE*UNIT_W-1:0] lane_words_i,
    input  logic                    unit_valid_i,
    output logic                    ser_bit_o,
    output logic                    ser_valid_o,
    input  logic                    chk_bit_i,
    input  logic                    chk_valid_i,
    output logic                    chk_lock_o,
    output logic                    chk_good_o,
    output logic                    chk_bad_o
);

    logic               hold_v;
    logic [FRAME_W-1:0] hold_frame;
    logic               take;

    ref_frame_build #(
        .NLANE  (NLANE),
        .DATA_W (DATA_W),
        .CTRL_W (CTRL_W)
    ) u_build (
        .clk          (clk),
        .rst_n        (rst_n),
        .lane_words_i (lane_words_i),
        .unit_valid_i (unit_valid_i),
        .take_i       (take),
        .hold_v_o     (hold_v),
        .hold_frame_o (hold_frame)
    );

    ref_frame_shift #(
        .FRAME_W (FRAME_W)
    ) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .hold_v_i     (hold_v),
        .hold_frame_i (hold_frame),
        .take_o       (take),
        .ser_bit_o    (ser_bit_o),
        .ser_valid_o  (ser_valid_o)
    );

    ref_frame_check #(
        .FRAME_W    (FRAME_W),
        .LOCK_GOOD  (LOCK_GOOD),
        .UNLOCK_BAD (UNLOCK_BAD)
    ) u_check (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_i   (chk_bit_i),
        .valid_i (chk_valid_i),
        .lock_o  (chk_lock_o),
        .good_o  (chk_good_o),
        .bad_o   (chk_bad_o)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (!ser_valid_o && !chk_lock_o && !chk_good_o && !chk_bad_o));

endmodule

// File: tb/deskew_ref_gen_tb.sv
`timescale 1ns/1ps
module deskew_ref_gen_tb;

    localparam int NL = 10;
    localparam int UW = 68;
    localparam int FW = 136;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NL*UW-1:0] lanes = '0;
    logic            uv = 1'b0;
    logic            ser_bit, ser_valid;
    logic            cbit = 1'b0, cvalid = 1'b0;
    logic            lock, good, bad;

    int err_cnt = 0;
    int chk_cnt = 0;

    always #2.5 clk = ~clk;

    deskew_ref_gen u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .lane_words_i (lanes),
        .unit_valid_i (uv),
        .ser_bit_o    (ser_bit),
        .ser_valid_o  (ser_valid),
        .chk_bit_i    (cbit),
        .chk_valid_i  (cvalid),
        .chk_lock_o   (lock),
        .chk_good_o   (good),
        .chk_bad_o    (bad)
    );

    // ---------------- serial capture ----------------
    logic [FW-1:0] rx_sh = '0;
    logic [FW-1:0] rx_frames [32];
    int rx_bits = 0, rx_nfr = 0;
    int run_cur = 0, last_run = 0, gap_err = 0;
    logic prev_v = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ser_valid) begin
                if (!prev_v && (rx_bits % FW) != 0) gap_err++;
                rx_sh = {rx_sh[FW-2:0], ser_bit};
                rx_bits++;
                run_cur++;
                if ((rx_bits % FW) == 0) begin
                    if (rx_nfr < 32) rx_frames[rx_nfr] = rx_sh;
                    rx_nfr++;
                end
            end else if (prev_v) begin
                last_run = run_cur;
                run_cur  = 0;
                if ((rx_bits % FW) != 0) gap_err++;
            end
            prev_v = ser_valid;
        end
    end

    // ---------------- helpers ----------------
    function automatic logic [23:0] crc_of(input logic [111:0] m);
        logic [23:0] c = 24'hB704CE;
        for (int i = 111; i >= 0; i--) begin
            logic f = c[23] ^ m[i];
            c = {c[22:0], 1'b0};
            if (f) c = c ^ 24'h864CFB;
        end
        return c;
    endfunction

    function automatic logic [FW-1:0] exp_frame(input logic [NL*UW-1:0] w);
        logic [111:0] b = 112'h0;
        b[111:80] = 32'hF6F62828;
        for (int n = 0; n < NL; n++) begin
            b[79-8*n -: 8] = w[n*UW + 56 +: 8];
        end
        return {b, crc_of(b)};
    endfunction

    function automatic logic [NL*UW-1:0] pat(input int s, input int second);
        logic [NL*UW-1:0] w = '0;
        for (int n = 0; n < NL; n++) begin
            logic [63:0] d = 64'h0123456789ABCDEF * 64'(s + 3) + 64'(n) * 64'h0F1E2D3C4B5A6978;
            if (second != 0) d = ~d ^ 64'hA5A5_0000_0000_5A5A;
            w[n*UW +: UW] = {4'(n + second), d};
        end
        return w;
    endfunction

    function automatic logic [FW-1:0] mk_frame(input int s);
        logic [111:0] b;
        b[111:80] = 32'hF6F62828;
        b[79:0]   = 80'(64'hC3D2E1F00F1E2D3C * 64'(s + 7)) ^ 80'(s);
        return {b, crc_of(b)};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
        chk_cnt++;
        if (!ok) begin
            err_cnt++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_unit(input logic [NL*UW-1:0] w);
        lanes = w;
        uv    = 1'b1;
        @(negedge clk);
        uv    = 1'b0;
    endtask

    int seen_good, seen_bad;

    task automatic send_bits(input logic [FW-1:0] f, input int nbits, input bit gaps);
        for (int i = 0; i < nbits; i++) begin
            cbit   = f[nbits-1-i];
            cvalid = 1'b1;
            @(negedge clk);
            if (good) seen_good++;
            if (bad)  seen_bad++;
            if (gaps) begin
                cvalid = 1'b0;
                @(negedge clk);
                if (good) seen_good++;
                if (bad)  seen_bad++;
            end
        end
        cvalid = 1'b0;
    endtask

    task automatic send_frames(input int s, input int count, input bit corrupt, input bit gaps);
        for (int k = 0; k < count; k++) begin
            logic [FW-1:0] f = mk_frame(s + k);
            if (corrupt) f[0] = ~f[0];
            send_bits(f, FW, gaps);
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        chk_cnt++;
        err_cnt++;
        $display("FAIL R6 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", err_cnt, chk_cnt);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        int base;
        logic [NL*UW-1:0] wa, wb, wc;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(!ser_valid && !lock && !good && !bad, "R1 reset outputs",
              FW'({ser_valid, lock, good, bad}), '0);

        // R2 R3 R4 sweep of lane patterns, one pair each
        base = rx_nfr;
        for (int s = 0; s < 8; s++) begin
            wa = (s == 6) ? '1 : (s == 7) ? '0 : pat(s, 0);
            drive_unit(wa);
            drive_unit(pat(s + 40, 1));
            repeat (145) @(negedge clk);
            check(rx_nfr == base + s + 1 && rx_frames[base + s] == exp_frame(wa),
                  "R2 R3 R4 frame content", rx_frames[base + s], exp_frame(wa));
        end
        check(rx_nfr == base + 8, "R5 one frame per pair", FW'(rx_nfr - base), FW'(8));
        check(gap_err == 0 && last_run == FW, "R6 contiguous valid run", FW'(last_run), FW'(FW));

        // R5 first unit of pair makes the frame, second does not
        base = rx_nfr;
        wa = pat(77, 0);
        drive_unit(wa);
        repeat (145) @(negedge clk);
        check(rx_nfr == base + 1 && rx_frames[base] == exp_frame(wa), "R5 first unit framed",
              rx_frames[base], exp_frame(wa));
        drive_unit(pat(78, 0));
        repeat (145) @(negedge clk);
        check(rx_nfr == base + 1, "R5 second unit silent", FW'(rx_nfr - base), FW'(1));

        // R7 R6 back-to-back pairs: waiting frame replaced, frames abut
        base = rx_nfr;
        wa = pat(90, 0); wb = pat(91, 0); wc = pat(92, 0);
        drive_unit(wa); drive_unit(pat(93, 1));
        drive_unit(wb); drive_unit(pat(94, 1));
        drive_unit(wc); drive_unit(pat(95, 1));
        repeat (300) @(negedge clk);
        check(rx_nfr == base + 2, "R7 frame count", FW'(rx_nfr - base), FW'(2));
        check(rx_frames[base] == exp_frame(wa), "R7 first frame", rx_frames[base], exp_frame(wa));
        check(rx_frames[base + 1] == exp_frame(wc), "R7 newest replaces waiting",
              rx_frames[base + 1], exp_frame(wc));
        check(last_run == 2 * FW && gap_err == 0, "R6 seamless back-to-back",
              FW'(last_run), FW'(2 * FW));

        // R10 junk prefix then a good frame at odd offset
        seen_good = 0; seen_bad = 0;
        send_bits(FW'(37'h1A5C3E9B7D), 37, 1'b0);
        send_frames(1, 1, 1'b0, 1'b0);
        check(seen_good == 1 && seen_bad == 0 && !lock, "R10 hunt finds frame",
              FW'({seen_good[7:0], seen_bad[7:0], lock}), FW'({8'd1, 8'd0, 1'b0}));

        // R8 second good frame locks
        seen_good = 0; seen_bad = 0;
        send_frames(2, 1, 1'b0, 1'b0);
        check(seen_good == 1 && lock, "R8 lock after two good", FW'({seen_good[7:0], lock}), FW'({8'd1, 1'b1}));

        // R9 three bad keep lock, a good clears the run
        seen_good = 0; seen_bad = 0;
        send_frames(3, 3, 1'b1, 1'b0);
        check(seen_bad == 3 && lock, "R9 three bad hold lock", FW'({seen_bad[7:0], lock}), FW'({8'd3, 1'b1}));
        send_frames(6, 1, 1'b0, 1'b0);
        send_frames(7, 3, 1'b1, 1'b0);
        check(seen_good == 1 && lock, "R9 good clears bad run", FW'({seen_good[7:0], lock}), FW'({8'd1, 1'b1}));
        send_frames(10, 1, 1'b1, 1'b0);
        check(seen_bad == 7 && !lock, "R9 fourth bad drops lock", FW'({seen_bad[7:0], lock}), FW'({8'd7, 1'b0}));

        // R10 bad frames while searching give no pulse
        seen_good = 0; seen_bad = 0;
        send_frames(11, 2, 1'b1, 1'b0);
        check(seen_good == 0 && seen_bad == 0 && !lock, "R10 quiet while hunting",
              FW'({seen_good[7:0], seen_bad[7:0]}), '0);

        // R11 break in the good run before lock
        seen_good = 0; seen_bad = 0;
        send_frames(13, 1, 1'b0, 1'b0);
        send_frames(14, 1, 1'b1, 1'b0);
        check(seen_bad == 1 && !lock, "R11 bad before lock", FW'({seen_bad[7:0], lock}), FW'({8'd1, 1'b0}));
        send_frames(15, 1, 1'b0, 1'b0);
        check(!lock && seen_good == 2, "R11 restart needs two good", FW'({seen_good[7:0], lock}), FW'({8'd2, 1'b0}));
        send_frames(16, 1, 1'b0, 1'b0);
        check(lock, "R11 relock", FW'(lock), FW'(1));

        // R10 bit gaps ignored: unlock, then relock with gaps
        send_frames(17, 4, 1'b1, 1'b0);
        check(!lock, "R9 unlock before gap test", FW'(lock), FW'(0));
        seen_good = 0; seen_bad = 0;
        send_frames(21, 2, 1'b0, 1'b1);
        check(seen_good == 2 && seen_bad == 0 && lock, "R10 gaps ignored",
              FW'({seen_good[7:0], seen_bad[7:0], lock}), FW'({8'd2, 8'd0, 1'b1}));

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", err_cnt, chk_cnt);
        $finish;
    end

endmodule